// File: doc/BRIEF.md
# Video Clock Divider Tap Selector

This block builds the clock-enable tree for a video subsystem. A source select picks one of several incoming clock-enable streams. A programmable main divider then thins that stream, producing one main tick for every N source pulses. Five taps count these main ticks and fire at the main rate divided by 1, 2, 4, 6 and 12. All taps are advanced by the same tick, so they stay in phase with one another.

Four consumers each choose a tap with a 4-bit code:
- an interlaced encoder,
- a progressive encoder,
- a converter output,
- a pixel transmitter.

Each consumer has its own gate, and each tap has its own gate. A master enable sits above all of them.

The outputs are single-cycle enable pulses in the system clock domain, not derived clocks. Configuration comes through a write port that carries a mask with every write. Only the masked bits of the addressed register change.

Top module: `vclk_tap_divider`

## Requirements
- R1: After reset every register is zero and no consumer output pulses.
- R2: Register 0 bits 7:0 hold the ratio minus one. A field value R produces one main tick per R+1 pulses of the selected source. With a source that is always high, a consumer on the /1 tap pulses every R+1 cycles, so R=54 gives 55 cycles and R=0 gives 1 cycle.
- R3: The taps fire once every 2, 4 and 12 main ticks for /2, /4 and /12, and once every 6 main ticks for /6.
- R4: Select codes 0, 1, 2, 3 and 4 choose taps /1, /2, /4, /6 and /12. Codes 5 to 15 produce no pulses. The select fields sit at these positions:
  - interlaced encoder: register 0 bits 31:28;
  - progressive encoder: register 0 bits 27:24;
  - pixel transmitter: register 3 bits 19:16;
  - converter output: register 3 bits 23:20.
- R5: Register 0 bit 16 enables the divider and bit 17 holds it in reset. Pulses occur only while bit 16 is 1 and bit 17 is 0.
- R6: Register 1 bits 0 to 4 gate the taps /1, /2, /4, /6 and /12. A consumer on a gated-off tap stays silent while the other consumers keep running.
- R7: Register 2 holds the consumer gates: bit 0 for the interlaced encoder, bit 2 for the progressive encoder, bit 4 for the converter output and bit 5 for the pixel transmitter. A cleared gate silences only that consumer.
- R8: Register 1 bit 19 is a master enable. While it is clear, every output is silent.
- R9: Register 1 bits 18:16 select which bit of the source-enable input drives the main divider.
- R10: Register 1 bit 15 is a soft reset that holds all tap phase counters at zero. While it is set, only /1 consumers pulse. After release, the first /12 pulse comes with the twelfth main tick.
- R11: A write changes only the bits set in the mask. All other bits of the addressed register keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEn | input | 8 | Candidate source clock-enable streams |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrMask | input | 32 | Per-bit write mask |
| wrData | input | 32 | Write data |
| intlClkEn | output | 1 | Interlaced encoder enable pulse |
| progClkEn | output | 1 | Progressive encoder enable pulse |
| dacClkEn | output | 1 | Converter output enable pulse |
| txClkEn | output | 1 | Pixel transmitter enable pulse |

## Verification
The bench builds the block with its package defaults: an 8-bit ratio field, 4-bit select codes and eight source streams. The 8-bit ratio lets the bench reach the divide-by-55 setting and the zero-ratio corner where the /1 tap fires every cycle. The 4-bit codes let it drive the invalid codes 5 and 15. The eight sources let it select a half-rate stream on input 3 and an idle one on input 5. The /12 interval at ratio 54 is 660 cycles, which keeps the full tap set within the measurement windows.

// File: rtl/vclk_tap_pkg.sv
package vclk_tap_pkg;

  localparam int RATIO_W   = 8;
  localparam int SEL_W     = 4;
  localparam int SRC_W     = 3;
  localparam int NUM_TAPS  = 5;
  localparam int NUM_CONS  = 4;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int NUM_SRC   = 1 << SRC_W;
  localparam int MAX_PER   = 12;
  localparam int PH_W      = $clog2(MAX_PER);
  localparam int TAP_IDX_W = $clog2(NUM_TAPS);

  // register addresses
  localparam int REG_DIV  = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_GATE = 2;
  localparam int REG_TX   = 3;

  // field positions
  localparam int DIV_EN_BIT    = 16;
  localparam int DIV_RST_BIT   = 17;
  localparam int INTL_SEL_LSB  = 28;
  localparam int PROG_SEL_LSB  = 24;
  localparam int SOFT_RST_BIT  = 15;
  localparam int SRC_SEL_LSB   = 16;
  localparam int MASTER_EN_BIT = 19;
  localparam int TX_SEL_LSB    = 16;
  localparam int DAC_SEL_LSB   = 20;
  localparam int GATE_INTL_BIT = 0;
  localparam int GATE_PROG_BIT = 2;
  localparam int GATE_DAC_BIT  = 4;
  localparam int GATE_TX_BIT   = 5;

  // consumer indices
  localparam int CONS_INTL = 0;
  localparam int CONS_PROG = 1;
  localparam int CONS_DAC  = 2;
  localparam int CONS_TX   = 3;

  function automatic int tapPeriod(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 6;
      default: return 12;
    endcase
  endfunction

  typedef struct packed {
    logic [RATIO_W-1:0]                ratio;
    logic                              divRun;
    logic                              divClear;
    logic                              phaseClear;
    logic                              masterEn;
    logic [SRC_W-1:0]                  srcSel;
    logic [NUM_TAPS-1:0]               tapGate;
    logic [NUM_CONS-1:0]               consGate;
    logic [NUM_CONS-1:0][SEL_W-1:0]    consSel;
  } cfg_t;

endpackage

// File: rtl/vclk_tap_ctrl.sv
module vclk_tap_ctrl
  import vclk_tap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrMask,
  input  logic [DATA_W-1:0] wrData,
  output cfg_t              cfg
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[r] <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(r))) begin
        regs[r] <= (regs[r] & ~wrMask) | (wrData & wrMask);
      end
    end
  end

  always_comb begin
    cfg = '0;
    cfg.ratio      = regs[REG_DIV][RATIO_W-1:0];
    cfg.divClear   = regs[REG_DIV][DIV_RST_BIT];
    cfg.divRun     = regs[REG_DIV][DIV_EN_BIT] & ~regs[REG_DIV][DIV_RST_BIT];
    cfg.phaseClear = regs[REG_CTRL][SOFT_RST_BIT];
    cfg.masterEn   = regs[REG_CTRL][MASTER_EN_BIT];
    cfg.srcSel     = regs[REG_CTRL][SRC_SEL_LSB +: SRC_W];
    cfg.tapGate    = regs[REG_CTRL][NUM_TAPS-1:0];
    cfg.consGate[CONS_INTL] = regs[REG_GATE][GATE_INTL_BIT];
    cfg.consGate[CONS_PROG] = regs[REG_GATE][GATE_PROG_BIT];
    cfg.consGate[CONS_DAC]  = regs[REG_GATE][GATE_DAC_BIT];
    cfg.consGate[CONS_TX]   = regs[REG_GATE][GATE_TX_BIT];
    cfg.consSel[CONS_INTL]  = regs[REG_DIV][INTL_SEL_LSB +: SEL_W];
    cfg.consSel[CONS_PROG]  = regs[REG_DIV][PROG_SEL_LSB +: SEL_W];
    cfg.consSel[CONS_DAC]   = regs[REG_TX][DAC_SEL_LSB +: SEL_W];
    cfg.consSel[CONS_TX]    = regs[REG_TX][TX_SEL_LSB +: SEL_W];
  end

endmodule

// File: rtl/vclk_tap_datapath.sv
module vclk_tap_datapath
  import vclk_tap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfg_t               cfg,
  input  logic [NUM_SRC-1:0] srcEn,
  output logic [NUM_CONS-1:0] consPulse
);

  logic [RATIO_W-1:0]  mainCnt;
  logic                srcHit;
  logic                mainTick;
  logic [NUM_TAPS-1:0] tapFire;
  logic [NUM_TAPS-1:0] tapLive;

  assign srcHit   = srcEn[cfg.srcSel];
  assign mainTick = cfg.divRun && srcHit && (mainCnt >= cfg.ratio);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= '0;
    end else if (cfg.divClear) begin
      mainCnt <= '0;
    end else if (cfg.divRun && srcHit) begin
      mainCnt <= (mainCnt >= cfg.ratio) ? '0 : mainCnt + 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int PER = tapPeriod(t);
    if (PER == 1) begin : g_direct
      assign tapFire[t] = mainTick;
    end else begin : g_count
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          phase <= '0;
        end else if (cfg.phaseClear) begin
          phase <= '0;
        end else if (mainTick) begin
          phase <= (phase == PH_W'(PER - 1)) ? '0 : phase + 1'b1;
        end
      end
      assign tapFire[t] = mainTick && !cfg.phaseClear && (phase == PH_W'(PER - 1));
    end
  end

  assign tapLive = tapFire & cfg.tapGate & {NUM_TAPS{cfg.masterEn}};

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic [SEL_W-1:0] sel;
    logic             pick;
    assign sel  = cfg.consSel[c];
    assign pick = (sel < SEL_W'(NUM_TAPS)) ? tapLive[sel[TAP_IDX_W-1:0]] : 1'b0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        consPulse[c] <= 1'b0;
      end else begin
        consPulse[c] <= pick && cfg.consGate[c];
      end
    end
  end

endmodule

// File: rtl/vclk_tap_divider.sv
module vclk_tap_divider
  import vclk_tap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrMask,
  input  logic [DATA_W-1:0]  wrData,
  output logic               intlClkEn,
  output logic               progClkEn,
  output logic               dacClkEn,
  output logic               txClkEn
);

  cfg_t                cfg;
  logic [NUM_CONS-1:0] consPulse;

  vclk_tap_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrMask (wrMask),
    .wrData (wrData),
    .cfg    (cfg)
  );

  vclk_tap_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .srcEn     (srcEn),
    .consPulse (consPulse)
  );

  assign intlClkEn = consPulse[CONS_INTL];
  assign progClkEn = consPulse[CONS_PROG];
  assign dacClkEn  = consPulse[CONS_DAC];
  assign txClkEn   = consPulse[CONS_TX];

endmodule

// File: rtl/vclk_tap_divider_chk.sv
module vclk_tap_divider_chk
  import vclk_tap_pkg::*;
(
  input logic clk,
  input logic rstN,
  input cfg_t cfg,
  input logic intlClkEn,
  input logic progClkEn,
  input logic dacClkEn,
  input logic txClkEn
);

  logic [NUM_CONS-1:0] outs;
  assign outs = {txClkEn, dacClkEn, progClkEn, intlClkEn};

  // R8: master enable off silences every consumer
  assert_master_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfg.masterEn) |-> (outs == '0));

  // R5: divider stopped or held in reset gives no pulses
  assert_div_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfg.divRun) |-> (outs == '0));

  // R4: out-of-range code on the interlaced encoder yields nothing
  assert_bad_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfg.consSel[CONS_INTL]) >= SEL_W'(NUM_TAPS)) |-> !intlClkEn);

  // R7: cleared consumer gate silences that consumer
  assert_cons_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfg.consGate[CONS_PROG]) |-> !progClkEn);

  // R10: during soft reset only /1 consumers may pulse
  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfg.phaseClear) && ($past(cfg.consSel[CONS_TX]) != '0)) |-> !txClkEn);

  // R6: a gated-off /2 tap never drives the progressive encoder
  assert_tap_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfg.tapGate[1]) && ($past(cfg.consSel[CONS_PROG]) == SEL_W'(1))) |-> !progClkEn);

endmodule

bind vclk_tap_divider vclk_tap_divider_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfg       (cfg),
  .intlClkEn (intlClkEn),
  .progClkEn (progClkEn),
  .dacClkEn  (dacClkEn),
  .txClkEn   (txClkEn)
);

// File: tb/vclk_tap_divider_tb.sv
`timescale 1ns/1ps
module vclk_tap_divider_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  srcEn = 8'h01;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrMask = '0;
  logic [31:0] wrData = '0;
  logic        intlClkEn, progClkEn, dacClkEn, txClkEn;
  logic [3:0]  outs;

  int checks = 0;
  int fails  = 0;

  localparam int C_INTL = 0;
  localparam int C_PROG = 1;
  localparam int C_DAC  = 2;
  localparam int C_TX   = 3;

  always #2.5 clk = ~clk;

  vclk_tap_divider u_dut (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrMask(wrMask), .wrData(wrData), .intlClkEn(intlClkEn),
    .progClkEn(progClkEn), .dacClkEn(dacClkEn), .txClkEn(txClkEn)
  );

  assign outs = {txClkEn, dacClkEn, progClkEn, intlClkEn};

  // source 3 is a half-rate stream
  initial begin
    forever begin
      @(negedge clk);
      srcEn[3] = ~srcEn[3];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] m, input logic [31:0] d);
    wrAddr = a; wrMask = m; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrMask = '0; wrData = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic getInterval(input int c, output int iv);
    int n;
    iv = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (outs[c]) begin
        n = 0;
        for (int j = 0; j < 4000; j++) begin
          @(negedge clk);
          n++;
          if (outs[c]) begin
            iv = n;
            break;
          end
        end
        break;
      end
    end
  endtask

  task automatic countPulses(input int c, input int win, output int cnt);
    cnt = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (outs[c]) cnt++;
    end
  endtask

  function automatic logic [31:0] divWord(input int ratio, input int iSel, input int pSel);
    return 32'(ratio) | (32'd1 << 16) | (32'(iSel) << 28) | (32'(pSel) << 24);
  endfunction

  function automatic logic [31:0] ctrlWord(input int src, input logic [4:0] gates);
    return 32'(gates) | (32'(src) << 16) | (32'd1 << 19);
  endfunction

  task automatic baseConfig(input int ratio);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F));
    wr(2'd2, 32'hFFFF_FFFF, 32'h35);
    wr(2'd3, 32'hFFFF_FFFF, (32'd2 << 16) | (32'd4 << 20));
    wr(2'd0, 32'hFFFF_FFFF, divWord(ratio, 0, 1));
    settle();
  endtask

  task automatic testReset();
    int cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (outs != 0) cnt++;
    end
    check(cnt == 0, "R1 reset silent", cnt, 0);
  endtask

  task automatic testRatio();
    int iv;
    baseConfig(54);
    getInterval(C_INTL, iv); check(iv == 55, "R2 /1 at ratio 54", iv, 55);
    getInterval(C_PROG, iv); check(iv == 110, "R3 /2 tap", iv, 110);
    getInterval(C_TX, iv);   check(iv == 220, "R3 /4 tap", iv, 220);
    getInterval(C_DAC, iv);  check(iv == 660, "R3 /12 tap", iv, 660);
    wr(2'd0, 32'hFFFF_FFFF, divWord(0, 0, 3));
    settle();
    getInterval(C_INTL, iv); check(iv == 1, "R2 /1 at ratio 0", iv, 1);
    getInterval(C_PROG, iv); check(iv == 6, "R4 code 3 is /6", iv, 6);
    wr(2'd0, 32'hFFFF_FFFF, divWord(4, 4, 3));
    settle();
    getInterval(C_INTL, iv); check(iv == 60, "R4 code 4 is /12", iv, 60);
    getInterval(C_PROG, iv); check(iv == 30, "R3 /6 at ratio 4", iv, 30);
  endtask

  task automatic testBadCodes();
    int cnt;
    wr(2'd0, 32'hFFFF_FFFF, divWord(1, 5, 1));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R4 code 5 silent", cnt, 0);
    wr(2'd0, 32'hFFFF_FFFF, divWord(1, 15, 1));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R4 code 15 silent", cnt, 0);
    countPulses(C_PROG, 100, cnt); check(cnt == 25, "R4 valid neighbour runs", cnt, 25);
  endtask

  task automatic testDivCtl();
    int cnt;
    wr(2'd0, 32'hFFFF_FFFF, divWord(1, 0, 1) | (32'd1 << 17));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R5 divider reset holds", cnt, 0);
    wr(2'd0, 32'hFFFF_FFFF, divWord(1, 0, 1) & ~(32'd1 << 16));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R5 divider disabled", cnt, 0);
    wr(2'd0, 32'hFFFF_FFFF, divWord(1, 0, 1));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 50, "R5 divider resumes", cnt, 50);
  endtask

  task automatic testGates();
    int cnt;
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1D));
    settle();
    countPulses(C_PROG, 100, cnt); check(cnt == 0, "R6 /2 tap gated", cnt, 0);
    countPulses(C_INTL, 100, cnt); check(cnt == 50, "R6 /1 tap still on", cnt, 50);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F));
    wr(2'd2, 32'hFFFF_FFFF, 32'h34);
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R7 interlaced gate off", cnt, 0);
    countPulses(C_PROG, 100, cnt); check(cnt == 25, "R7 progressive gate on", cnt, 25);
    wr(2'd2, 32'hFFFF_FFFF, 32'h15);
    settle();
    countPulses(C_TX, 200, cnt); check(cnt == 0, "R7 transmitter gate off", cnt, 0);
    wr(2'd2, 32'hFFFF_FFFF, 32'h35);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F) & ~(32'd1 << 19));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R8 master off", cnt, 0);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F));
    settle();
  endtask

  task automatic testSource();
    int iv, cnt;
    wr(2'd0, 32'hFFFF_FFFF, divWord(4, 0, 1));
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(3, 5'h1F));
    settle();
    getInterval(C_INTL, iv); check(iv == 10, "R9 half-rate source", iv, 10);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(5, 5'h1F));
    settle();
    countPulses(C_INTL, 100, cnt); check(cnt == 0, "R9 idle source", cnt, 0);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F));
    settle();
  endtask

  task automatic testSoftReset();
    int cnt, ticks;
    wr(2'd0, 32'hFFFF_FFFF, divWord(2, 0, 1));
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F) | (32'd1 << 15));
    settle();
    countPulses(C_PROG, 60, cnt); check(cnt == 0, "R10 /2 held", cnt, 0);
    countPulses(C_INTL, 60, cnt); check(cnt == 20, "R10 /1 runs", cnt, 20);
    wr(2'd1, 32'hFFFF_FFFF, ctrlWord(0, 5'h1F));
    ticks = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (intlClkEn) ticks++;
      if (dacClkEn) break;
    end
    check(ticks == 12, "R10 first /12 after release", ticks, 12);
  endtask

  task automatic testMask();
    int iv;
    wr(2'd0, 32'hFFFF_FFFF, divWord(4, 0, 1));
    settle();
    wr(2'd0, 32'hF000_0000, 32'h1FFF_FFFF);
    settle();
    getInterval(C_INTL, iv); check(iv == 10, "R11 masked field updated", iv, 10);
    getInterval(C_PROG, iv); check(iv == 10, "R11 other bits kept", iv, 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRatio();
    testBadCodes();
    testDivCtl();
    testGates();
    testSource();
    testSoftReset();
    testMask();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule